// File: doc/BRIEF.md
# Mailbox Command Sequencer with Reply Checksum

This engine sits on the host side of a shared message area and runs one complete request/reply exchange with a coprocessor. A single start pulse picks one of three fixed command templates. The engine writes the five-word message into the shared RAM, rings the coprocessor doorbell, and then polls the reply mailbox at a fixed spacing until it reads a non-zero word or runs out of polls. On a reply it reads the five message words back into a result buffer. It then checks the additive checksum of those words and turns the reply word into a small error index.

All traffic uses a simple request/acknowledge register-bus master port. A transfer completes on a clock edge where both request and acknowledge are high, and address, direction and write data stay stable until then. In every case the engine finishes by writing zero to the reply mailbox. It then raises `done_o` for one cycle, with the error index valid on `err_o` and the returned words on `result_o`.

Top module: `mbox_cmd_seq`

## Requirements
- R1: For command select 0, 1 or 2 the first five transfers are writes to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. Their data is header, command, argument count, argument 0 and checksum. The templates are select 0 = (1,1,1,1,4), select 1 = (1,2,1,1,5) and select 2 = (1,2,1,2,6). The bus request is held with address and direction stable until it is acknowledged.
- R2: The sixth transfer writes the value 1 to the doorbell at address 0x10. No poll takes place before it.
- R3: The engine polls the reply mailbox by reading address 0x14. Between consecutive polls the request stays low for exactly POLL_GAP cycles. At most POLL_MAX polls are made, and a non-zero word returned by the last allowed poll counts as a reply.
- R4: If POLL_MAX polls all return zero, the engine reads nothing from the message RAM. It reports error index 5, and `result_o` is all zero.
- R5: After a non-zero poll, the engine reads addresses 0x100 to 0x110 in order. Word i is stored in `result_o[32*i +: 32]`.
- R6: The last transfer of every started transaction, timeout included, writes 0 to address 0x14.
- R7: Reply word 1 with a consistent checksum gives error index 0.
- R8: If the 32-bit sum of returned words 0 to 3 differs from returned word 4, the error index is 3, whatever the reply word was.
- R9: Any other reply word has bit 31 cleared. The error index is then the position of its lowest set bit plus one, or 0 if no bit remains. For example, 0x80000002 gives 2, 0x80000008 gives 4, 0x00000010 gives 5 and 0x80000000 gives 0.
- R10: A command select of 3 makes no bus transfer. It raises `done_o` in the cycle after the start is accepted, with error index 32.
- R11: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a one-cycle pulse and is never high together with `busy_o`. A start while busy is ignored.
- R12: After reset, `busy_o`, `done_o` and `bus_req_o` are low, and `err_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| cmd_sel_i | input | 2 | Command select (0 info, 1 refresh, 2 vendor, 3 invalid) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 6 | Error index of the last transaction |
| result_o | output | 160 | Five returned message words, word 0 in the low bits |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 12 | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
Two decisions can land on the same acknowledge edge: the poll that exhausts the budget and the arrival of a non-zero reply. The bench's coprocessor model can make the reply visible on exactly the POLL_MAX-th poll, or one poll later. In the first case the engine must go on to the five-word readback and report success. In the second it must skip the readback and report index 5. A second collision is a reply that carries error flags together with a wrong checksum. There the checksum override must win, and the bench judges this from the error index and the logged bus sequence.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 5;
    localparam int ERR_W     = 6;

    localparam logic [11:0] MSG_BASE_ADDR = 12'h100;
    localparam logic [11:0] DOORBELL_ADDR = 12'h010;
    localparam logic [11:0] HOSTBOX_ADDR  = 12'h014;

    localparam logic [ERR_W-1:0] ERR_NONE    = 6'd0;
    localparam logic [ERR_W-1:0] ERR_CHKSUM  = 6'd3;
    localparam logic [ERR_W-1:0] ERR_TIMEOUT = 6'd5;
    localparam logic [ERR_W-1:0] ERR_BADSEL  = 6'd32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RING,
        ST_POLL,
        ST_GAP,
        ST_FETCH,
        ST_RELEASE
    } seq_state_e;
endpackage

// File: rtl/mbox_cmd_rom.sv
module mbox_cmd_rom
    import mbox_seq_pkg::*;
(
    input  logic [1:0]                  sel_i,
    output logic [MSG_WORDS*WORD_W-1:0] words_o
);
    logic [WORD_W-1:0] hdr, opc, argc, arg0, sum;

    always_comb begin
        hdr  = WORD_W'(1);
        opc  = (sel_i == 2'd0) ? WORD_W'(1) : WORD_W'(2);
        argc = WORD_W'(1);
        arg0 = (sel_i == 2'd2) ? WORD_W'(2) : WORD_W'(1);
        sum  = hdr + opc + argc + arg0;
        words_o = {sum, arg0, argc, opc, hdr};
    end
endmodule

// File: rtl/mbox_reply_check.sv
module mbox_reply_check
    import mbox_seq_pkg::*;
(
    input  logic [WORD_W-1:0]           code_i,
    input  logic [MSG_WORDS*WORD_W-1:0] words_i,
    output logic [ERR_W-1:0]            err_o
);
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] flags;

    always_comb begin
        sum = '0;
        for (int i = 0; i < MSG_WORDS - 1; i++) begin
            sum = sum + words_i[i*WORD_W +: WORD_W];
        end
        flags = code_i;
        flags[WORD_W-1] = 1'b0;
        err_o = ERR_NONE;
        if (sum != words_i[(MSG_WORDS-1)*WORD_W +: WORD_W]) begin
            err_o = ERR_CHKSUM;
        end else if (code_i != WORD_W'(1)) begin
            for (int b = WORD_W - 2; b >= 0; b--) begin
                if (flags[b]) err_o = ERR_W'(b + 1);
            end
        end
    end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_seq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int POLL_GAP = 625,
    parameter int POLL_MAX = 200000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [1:0]                  cmd_sel_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [ERR_W-1:0]            err_o,
    output logic [MSG_WORDS*WORD_W-1:0] result_o,
    output logic                        bus_req_o,
    output logic                        bus_we_o,
    output logic [ADDR_W-1:0]           bus_addr_o,
    output logic [WORD_W-1:0]           bus_wdata_o,
    input  logic                        bus_ack_i,
    input  logic [WORD_W-1:0]           bus_rdata_i
);
    localparam int CNT_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int IDX_W = 3;
    localparam int RES_W = MSG_WORDS * WORD_W;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] polls;
        logic [GAP_W-1:0] gap;
        logic [1:0]       sel;
        logic [WORD_W-1:0] code;
        logic             timed_out;
        logic [RES_W-1:0] result;
        logic             busy;
        logic             done;
        logic [ERR_W-1:0] err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [RES_W-1:0] tmpl;
    logic [ERR_W-1:0] chk_err;
    logic             xfer;

    mbox_cmd_rom u_rom (
        .sel_i   (r_q.sel),
        .words_o (tmpl)
    );

    mbox_reply_check u_check (
        .code_i  (r_q.code),
        .words_i (r_q.result),
        .err_o   (chk_err)
    );

    assign xfer = bus_req_o && bus_ack_i;

    // Bus drive derived from the registered state
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (r_q.st)
            ST_SEND: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b1;
                bus_addr_o = ADDR_W'(MSG_BASE_ADDR) + ADDR_W'({r_q.idx, 2'b00});
                for (int i = 0; i < MSG_WORDS; i++) begin
                    if (r_q.idx == IDX_W'(i)) bus_wdata_o = tmpl[i*WORD_W +: WORD_W];
                end
            end
            ST_RING: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = ADDR_W'(DOORBELL_ADDR);
                bus_wdata_o = WORD_W'(1);
            end
            ST_POLL: begin
                bus_req_o  = 1'b1;
                bus_addr_o = ADDR_W'(HOSTBOX_ADDR);
            end
            ST_FETCH: begin
                bus_req_o  = 1'b1;
                bus_addr_o = ADDR_W'(MSG_BASE_ADDR) + ADDR_W'({r_q.idx, 2'b00});
            end
            ST_RELEASE: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b1;
                bus_addr_o = ADDR_W'(HOSTBOX_ADDR);
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (cmd_sel_i == 2'd3) begin
                        r_d.done = 1'b1;
                        r_d.err  = ERR_BADSEL;
                    end else begin
                        r_d.st        = ST_SEND;
                        r_d.busy      = 1'b1;
                        r_d.sel       = cmd_sel_i;
                        r_d.idx       = '0;
                        r_d.polls     = '0;
                        r_d.gap       = '0;
                        r_d.code      = '0;
                        r_d.timed_out = 1'b0;
                        r_d.result    = '0;
                    end
                end
            end
            ST_SEND: begin
                if (xfer) begin
                    if (r_q.idx == IDX_W'(MSG_WORDS - 1)) r_d.st = ST_RING;
                    else r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_RING: begin
                if (xfer) r_d.st = ST_POLL;
            end
            ST_POLL: begin
                if (xfer) begin
                    if (bus_rdata_i != '0) begin
                        r_d.code = bus_rdata_i;
                        r_d.idx  = '0;
                        r_d.st   = ST_FETCH;
                    end else begin
                        r_d.polls = r_q.polls + 1'b1;
                        if (r_q.polls + 1'b1 == CNT_W'(POLL_MAX)) begin
                            r_d.timed_out = 1'b1;
                            r_d.st        = ST_RELEASE;
                        end else begin
                            r_d.gap = '0;
                            r_d.st  = ST_GAP;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap == GAP_W'(POLL_GAP - 1)) r_d.st = ST_POLL;
                else r_d.gap = r_q.gap + 1'b1;
            end
            ST_FETCH: begin
                if (xfer) begin
                    for (int i = 0; i < MSG_WORDS; i++) begin
                        if (r_q.idx == IDX_W'(i)) r_d.result[i*WORD_W +: WORD_W] = bus_rdata_i;
                    end
                    if (r_q.idx == IDX_W'(MSG_WORDS - 1)) r_d.st = ST_RELEASE;
                    else r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_RELEASE: begin
                if (xfer) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.err  = r_q.timed_out ? ERR_TIMEOUT : chk_err;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = r_q.busy;
    assign done_o   = r_q.done;
    assign err_o    = r_q.err;
    assign result_o = r_q.result;
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk
    import mbox_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [WORD_W-1:0] bus_wdata_o,
    input logic              bus_ack_i
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_req_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

    p_ring_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_addr_o == ADDR_W'(DOORBELL_ADDR)) |-> (bus_we_o && bus_wdata_o == WORD_W'(1)));

    p_host_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(HOSTBOX_ADDR)) |-> (bus_wdata_o == '0));
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
    localparam int GAP = 3;
    localparam int PMAX = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   cmd_sel = 2'd0;
    logic         busy, done;
    logic [5:0]   err;
    logic [159:0] result;
    logic         req, we;
    logic [11:0]  addr;
    logic [31:0]  wdata;
    logic         ack = 1'b0;
    logic [31:0]  rdata;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    mbox_cmd_seq #(.ADDR_W(12), .POLL_GAP(GAP), .POLL_MAX(PMAX)) u_mbox_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_sel_i(cmd_sel),
        .busy_o(busy), .done_o(done), .err_o(err), .result_o(result),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_ack_i(ack), .bus_rdata_i(rdata)
    );

    // Coprocessor model with a transfer log
    logic [31:0] msg [5];
    logic [31:0] rep [5];
    logic [31:0] resp_code = 32'd1;
    int          reply_after = 1;
    logic        clr = 1'b0;
    int          polls = 0;
    int          idle_cnt = 0;
    int          gap_log [8];
    int          log_n = 0;
    logic [11:0] log_addr [32];
    logic        log_we [32];
    logic [31:0] log_data [32];

    always_comb begin
        rdata = 32'd0;
        if (addr >= 12'h100 && addr <= 12'h110) rdata = msg[(addr - 12'h100) >> 2];
        else if (addr == 12'h014 && polls + 1 >= reply_after) rdata = resp_code;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else begin
            ack <= req && !ack;
            if (!req) idle_cnt <= idle_cnt + 1;
            if (clr) begin
                log_n <= 0;
                polls <= 0;
            end else if (req && ack) begin
                if (log_n < 32) begin
                    log_addr[log_n] <= addr;
                    log_we[log_n]   <= we;
                    log_data[log_n] <= we ? wdata : rdata;
                    log_n <= log_n + 1;
                end
                if (we && addr >= 12'h100 && addr <= 12'h110) msg[(addr - 12'h100) >> 2] <= wdata;
                if (!we && addr == 12'h014) begin
                    if (polls < 8) gap_log[polls] <= idle_cnt;
                    idle_cnt <= 0;
                    polls <= polls + 1;
                    if (polls + 1 >= reply_after) begin
                        for (int i = 0; i < 5; i++) msg[i] <= rep[i];
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tmpl_word(input logic [1:0] sel, input int i);
        logic [31:0] w [5];
        w[0] = 32'd1;
        w[1] = (sel == 2'd0) ? 32'd1 : 32'd2;
        w[2] = 32'd1;
        w[3] = (sel == 2'd2) ? 32'd2 : 32'd1;
        w[4] = w[0] + w[1] + w[2] + w[3];
        return w[i];
    endfunction

    function automatic logic [159:0] rep_vec();
        return {rep[4], rep[3], rep[2], rep[1], rep[0]};
    endfunction

    task automatic set_reply(input logic [31:0] a, input logic [31:0] b, input logic bad_sum);
        rep[0] = 32'd2; rep[1] = a; rep[2] = 32'd1; rep[3] = b;
        rep[4] = rep[0] + rep[1] + rep[2] + rep[3] + (bad_sum ? 32'd1 : 32'd0);
    endtask

    task automatic run_cmd(input logic [1:0] sel, input logic [31:0] code, input int after,
                           output logic [5:0] e, output logic [159:0] res);
        resp_code = code;
        reply_after = after;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1; cmd_sel = sel;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) break;
            @(negedge clk);
        end
        e = err;
        res = result;
    endtask

    task automatic check_frame(input string tag, input logic [1:0] sel, input int npoll, input logic fetched);
        int base;
        for (int i = 0; i < 5; i++) begin
            check({tag, " R1 addr"}, log_addr[i], 12'h100 + 12'(4 * i));
            check({tag, " R1 data"}, {log_we[i], log_data[i]}, {1'b1, tmpl_word(sel, i)});
        end
        check({tag, " R2 doorbell"}, {log_we[5], log_addr[5], log_data[5]}, {1'b1, 12'h010, 32'd1});
        for (int i = 0; i < npoll; i++) begin
            check({tag, " R3 poll"}, {log_we[6+i], log_addr[6+i]}, {1'b0, 12'h014});
        end
        base = 6 + npoll;
        if (fetched) begin
            for (int i = 0; i < 5; i++) begin
                check({tag, " R5 fetch"}, {log_we[base+i], log_addr[base+i]}, {1'b0, 12'h100 + 12'(4 * i)});
            end
            base = base + 5;
        end
        check({tag, " R4/R5 length"}, log_n, base + 1);
        check({tag, " R6 release"}, {log_we[base], log_addr[base], log_data[base]}, {1'b1, 12'h014, 32'd0});
    endtask

    task automatic t_reset();
        check("R12 busy", busy, 0);
        check("R12 done", done, 0);
        check("R12 req", req, 0);
        check("R12 err", err, 0);
        check("R12 result", result, 0);
    endtask

    task automatic t_success_all();
        logic [5:0] e; logic [159:0] res;
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < 5; i++) rep[i] = tmpl_word(2'(s), i);
            rep[3] = 32'h0000_0040 + 32'(s);
            rep[4] = rep[0] + rep[1] + rep[2] + rep[3];
            run_cmd(2'(s), 32'd1, 2, e, res);
            check("R7 err", e, 0);
            check("R5 result", res, rep_vec());
            check_frame("success", 2'(s), 2, 1'b1);
            check("R3 spacing", gap_log[1], GAP);
        end
    endtask

    task automatic t_error_codes();
        logic [5:0] e; logic [159:0] res;
        set_reply(32'd2, 32'd7, 1'b0);
        run_cmd(2'd1, 32'h8000_0002, 1, e, res);
        check("R9 0x80000002", e, 2);
        run_cmd(2'd1, 32'h8000_0008, 1, e, res);
        check("R9 0x80000008", e, 4);
        run_cmd(2'd0, 32'h0000_0010, 3, e, res);
        check("R9 0x00000010", e, 5);
        run_cmd(2'd0, 32'h8000_0000, 1, e, res);
        check("R9 0x80000000", e, 0);
        check_frame("err", 2'd0, 1, 1'b1);
    endtask

    task automatic t_checksum();
        logic [5:0] e; logic [159:0] res;
        set_reply(32'd2, 32'd9, 1'b1);
        run_cmd(2'd2, 32'd1, 1, e, res);
        check("R8 ok-code bad sum", e, 3);
        check("R8 result kept", res, rep_vec());
        run_cmd(2'd2, 32'h8000_0008, 1, e, res);
        check("R8 flagged bad sum", e, 3);
    endtask

    task automatic t_timeout_edge();
        logic [5:0] e; logic [159:0] res;
        set_reply(32'd1, 32'd3, 1'b0);
        run_cmd(2'd0, 32'd1, PMAX, e, res);
        check("R3 reply on last poll", e, 0);
        check_frame("lastpoll", 2'd0, PMAX, 1'b1);
        run_cmd(2'd0, 32'd1, PMAX + 1, e, res);
        check("R4 timeout index", e, 5);
        check("R4 result zero", res, 0);
        check_frame("timeout", 2'd0, PMAX, 1'b0);
        check("R3 spacing", gap_log[PMAX-1], GAP);
    endtask

    task automatic t_bad_select();
        logic [5:0] e; logic [159:0] res;
        run_cmd(2'd3, 32'd1, 1, e, res);
        check("R10 index", e, 32);
        check("R10 no bus", log_n, 0);
        check("R10 not busy", busy, 0);
    endtask

    task automatic t_busy_ignore();
        set_reply(32'd1, 32'd5, 1'b0);
        resp_code = 32'd1;
        reply_after = 3;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1; cmd_sel = 2'd0;
        @(negedge clk); start = 1'b0;
        check("R11 busy after start", busy, 1);
        for (int i = 0; i < 400; i++) begin
            if (done) break;
            if (i % 5 == 2) begin
                start = 1'b1; cmd_sel = 2'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R11 done", done, 1);
        check("R11 busy low at done", busy, 0);
        check("R11 err", err, 0);
        check_frame("busy", 2'd0, 3, 1'b1);
        @(negedge clk);
        check("R11 done one cycle", done, 0);
        check("R11 no restart", busy, 0);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            rep[i] = 32'd0;
            msg[i] = 32'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_success_all();
        t_error_codes();
        t_checksum();
        t_timeout_edge();
        t_bad_select();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule